// File: doc/BRIEF.md
# Eight-bit timer with two compare outputs

The block is an 8-bit up-counter with two compare channels that together steer one output pin. The counter advances on a detected high-to-low transition of a selected count source: a stopped level, one of two prescaled copies of the system clock, or an external input. Each compare channel carries its own output action: leave the pin alone, drive it low, drive it high, or toggle it. The action fires when the counter value becomes equal to that channel's compare value.

When both channels fire in the same cycle, a fixed priority picks the single action that is applied. The edge detector watches the output of the source selector. If a rewrite of the select field moves the selected level from 1 to 0, that counts as a falling edge and adds one extra count. This side effect is part of the modelled behaviour.

Software programs the block through a one-cycle write port with five addresses: control, counter, compare A, compare B and flag clear. The pin, the counter value, the two match flags and the overflow flag are outputs. The external count input is assumed to be synchronous to `clk` already.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: Control bits [1:0] select the count source: 00 stops counting, 01 gives one count every 8 `clk` cycles, 10 one count every 64 cycles, 11 follows `ext_clk`.
- R2: The counter adds one when the selected source goes from 1 to 0. A rise of the source does not count.
- R3: A control write that moves the selected level from 1 to 0 adds exactly one count. A control write that moves the level from 0 to 1 adds none.
- R4: A counter write (address 1) in the same cycle as a count edge loads the written value, and that edge is lost.
- R5: A count from 255 wraps the counter to 0 and sets `ovf_flag`. Writing 1 to bit 2 at address 4 clears the flag.
- R6: A channel has a match event in the first cycle that the counter equals its compare register (A at address 2, B at address 3). The event sets that channel's flag. Writing 1 to bit 0 (A) or bit 1 (B) at address 4 clears the flag; a set in the same cycle wins over the clear.
- R7: The action fields are control bits [3:2] for channel A and [5:4] for channel B. The codes are 00 no change, 01 drive 0, 10 drive 1 and 11 toggle. `tmr_out` takes the new level on the clock edge that follows the match event.
- R8: If both channels have a match event in the same cycle, one action is applied, chosen by the priority toggle > drive 1 > drive 0 > no change.
- R9: After reset the counter is 0, both compare registers are 255, the source is stopped, and `tmr_out` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External count source, already synchronous to clk |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | 0 control, 1 counter, 2 compare A, 3 compare B, 4 flag clear |
| wr_data | input | 8 | Write data |
| tmr_out | output | 1 | Timer output pin |
| count | output | 8 | Current counter value |
| match_a_flag | output | 1 | Sticky match flag of channel A |
| match_b_flag | output | 1 | Sticky match flag of channel B |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Errors in the source selector or the edge register show up on `count` within one count period. They appear as a changed count rate, an extra or missing count after a select rewrite, or a counter write that loses to an edge. Errors in the compare state or the priority resolver show up on `tmr_out` and the match flags on the clock edge after the counter reaches the compare value. Loading both compare registers with the same value, for every pair of action codes and both starting pin levels, makes each wrong priority choice show on the pin.

// File: rtl/tmr8_pkg.sv
// Shared types and constants for the dual-compare 8-bit timer.
// Assumes a single synchronous clock domain for all users.
package tmr8_pkg;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_CH = 2;

    // count source select codes
    localparam logic [1:0] SRC_STOP  = 2'b00;
    localparam logic [1:0] SRC_DIV_L = 2'b01;
    localparam logic [1:0] SRC_DIV_H = 2'b10;
    localparam logic [1:0] SRC_EXT   = 2'b11;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPA = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
    localparam logic [ADDR_W-1:0] A_FCLR = 3'd4;

    // output action; numeric order equals priority order
    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TOG  = 2'b11
    } act_e;
endpackage

// File: rtl/tmr8_src_sel.sv
// Count-source selector and falling-edge detector.
// A free-running prescaler gives two roughly 50% duty clocks. The selector
// output feeds the edge register directly, so a select rewrite that moves
// the level from 1 to 0 produces one count pulse.
// Assumes ext_clk is already synchronous to clk.
module tmr8_src_sel
    import tmr8_pkg::*;
#(
    parameter int DIV_L_LOG2 = 3,
    parameter int DIV_H_LOG2 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       ext_clk,
    output logic       cnt_tick
);
    localparam int PRE_W = DIV_H_LOG2;

    logic [PRE_W-1:0] pre_q;
    logic             sel_lvl;
    logic             lvl_q;

    // free-running prescaler
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // pick the level of the selected source
    always_comb begin
        unique case (src_sel)
            SRC_DIV_L: sel_lvl = pre_q[DIV_L_LOG2-1];
            SRC_DIV_H: sel_lvl = pre_q[DIV_H_LOG2-1];
            SRC_EXT:   sel_lvl = ext_clk;
            default:   sel_lvl = 1'b0;
        endcase
    end

    // remember last cycle's selected level
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= sel_lvl;
    end

    // a count pulse when the level was high and is now low
    assign cnt_tick = lvl_q & ~sel_lvl;

    // R1: a source held stopped never produces a count pulse
    p_stop_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_STOP && $past(src_sel) == SRC_STOP) |-> !cnt_tick);
    // R2: an external high-to-low transition under a steady select counts
    p_ext_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_EXT && $past(src_sel) == SRC_EXT
         && $past(ext_clk) && !ext_clk) |-> cnt_tick);
endmodule

// File: rtl/tmr8_cmp_ch.sv
// One compare channel: compare register, match-event detector and sticky flag.
// The event fires in the first cycle that the counter equals the compare
// value. A flag set wins over a clear in the same cycle.
module tmr8_cmp_ch
    import tmr8_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    input  logic         flag_clr,
    output logic         match_ev,
    output logic         flag
);
    logic [W-1:0] cmp_q;
    logic         eq_now;
    logic         eq_prev;

    // compare register, reset to all ones
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '1;
        else if (cmp_wr) cmp_q <= wr_data;
    end

    assign eq_now = (cnt == cmp_q);

    // previous-cycle equality, used to find the first equal cycle
    always_ff @(posedge clk) begin
        if (!rst_n) eq_prev <= 1'b0;
        else        eq_prev <= eq_now;
    end

    assign match_ev = eq_now & ~eq_prev;

    // sticky match flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (match_ev) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // R6: an event always leaves the flag set
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match_ev |=> flag);
    // R6: a clear without an event leaves the flag low
    p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !match_ev) |=> !flag);
endmodule

// File: rtl/tmr8_out_ctl.sv
// Output pin control: resolves the actions of the two channels and updates
// the pin one edge after the event. On simultaneous events, the action with
// the higher priority is applied (toggle > high > low > none).
module tmr8_out_ctl
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_a,
    input  logic ev_b,
    input  act_e act_a,
    input  act_e act_b,
    output logic pin
);
    act_e win;

    // choose the single action to apply this cycle
    always_comb begin
        if (ev_a && ev_b)  win = (act_a > act_b) ? act_a : act_b;
        else if (ev_a)     win = act_a;
        else if (ev_b)     win = act_b;
        else               win = ACT_NONE;
    end

    // apply the chosen action to the pin register
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else begin
            unique case (win)
                ACT_LOW:  pin <= 1'b0;
                ACT_HIGH: pin <= 1'b1;
                ACT_TOG:  pin <= ~pin;
                default:  pin <= pin;
            endcase
        end
    end

    // R7: with no event the pin holds
    p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_a && !ev_b) |=> $stable(pin));
    // R8: toggle on either side of a double event flips the pin
    p_tog_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_a && ev_b && (act_a == ACT_TOG || act_b == ACT_TOG))
        |=> pin != $past(pin));
    // R8: drive-high beats drive-low and no-change when no toggle is present
    p_high_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_a && ev_b && act_a != ACT_TOG && act_b != ACT_TOG
         && (act_a == ACT_HIGH || act_b == ACT_HIGH)) |=> pin);
endmodule

// File: rtl/tmr8_dual_cmp.sv
// Top of the 8-bit timer with two compare outputs.
// Holds the control register and the counter, decodes the write port, and
// connects the source selector, two compare channels and the pin control.
// Assumes one write per cycle and ext_clk synchronous to clk.
module tmr8_dual_cmp
    import tmr8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              tmr_out,
    output logic [CNT_W-1:0]  count,
    output logic              match_a_flag,
    output logic              match_b_flag,
    output logic              ovf_flag
);
    logic [1:0]       src_q;
    act_e             act_q [NUM_CH];
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             ctrl_wr, cnt_wr, fclr_wr;
    logic [NUM_CH-1:0] cmp_wr, ev, flg;
    logic             unused_hi;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign cnt_wr  = wr_en && (wr_addr == A_CNT);
    assign fclr_wr = wr_en && (wr_addr == A_FCLR);
    assign cmp_wr[0] = wr_en && (wr_addr == A_CMPA);
    assign cmp_wr[1] = wr_en && (wr_addr == A_CMPB);
    assign unused_hi = ^wr_data[CNT_W-1:6];

    // control register: source select and both action fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= SRC_STOP;
            act_q[0] <= ACT_NONE;
            act_q[1] <= ACT_NONE;
        end else if (ctrl_wr) begin
            src_q    <= wr_data[1:0];
            act_q[0] <= act_e'(wr_data[3:2]);
            act_q[1] <= act_e'(wr_data[5:4]);
        end
    end

    tmr8_src_sel u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_q),
        .ext_clk  (ext_clk),
        .cnt_tick (tick)
    );

    // counter: a write wins over a count pulse
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= wr_data;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    // overflow flag: set on wrap, cleared by writing 1 to bit 2
    always_ff @(posedge clk) begin
        if (!rst_n)                                ovf_flag <= 1'b0;
        else if (tick && !cnt_wr && (&cnt_q))      ovf_flag <= 1'b1;
        else if (fclr_wr && wr_data[2])            ovf_flag <= 1'b0;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr8_cmp_ch #(.W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmp_wr   (cmp_wr[i]),
            .wr_data  (wr_data),
            .cnt      (cnt_q),
            .flag_clr (fclr_wr && wr_data[i]),
            .match_ev (ev[i]),
            .flag     (flg[i])
        );
    end

    tmr8_out_ctl u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_a  (ev[0]),
        .ev_b  (ev[1]),
        .act_a (act_q[0]),
        .act_b (act_q[1]),
        .pin   (tmr_out)
    );

    assign count        = cnt_q;
    assign match_a_flag = flg[0];
    assign match_b_flag = flg[1];

    // R4: a counter write always lands, whatever the count pulse does
    p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(wr_data));
    // R2: a count pulse without a write adds exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> cnt_q == $past(cnt_q) + 8'd1);
    // R1: without pulse or write the counter holds
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_q));
    // R5: counting past 255 gives 0 and a set overflow flag
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q == 8'hFF) |=> (ovf_flag && cnt_q == 8'h00));
endmodule

// File: tb/tmr8_dual_cmp_tb_top.sv
`timescale 1ns/1ps
// Directed bench for tmr8_dual_cmp: one task per scenario, each checks itself.
module tmr8_dual_cmp_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tmr_out;
    logic [7:0] count;
    logic       match_a_flag, match_b_flag, ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr8_dual_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tmr_out(tmr_out), .count(count),
        .match_a_flag(match_a_flag), .match_b_flag(match_b_flag),
        .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctrl(input logic [1:0] src, input logic [1:0] aa,
                                        input logic [1:0] ab);
        return {2'b00, ab, aa, src};
    endfunction

    // R9: state after reset
    task automatic t_reset();
        chk(count == 8'd0, "R9 count", count, 0);
        chk(tmr_out == 1'b0, "R9 pin", tmr_out, 0);
        chk({match_a_flag, match_b_flag, ovf_flag} == 3'b000, "R9 flags",
            {match_a_flag, match_b_flag, ovf_flag}, 0);
        idle(20);
        chk(count == 8'd0, "R1 stopped after reset", count, 0);
    endtask

    // R1: prescaled rates and stopped source
    task automatic t_rates();
        logic [7:0] c0;
        wr(3'd0, ctrl(2'b01, 2'b00, 2'b00));
        idle(3); c0 = count; idle(64);
        chk(count - c0 == 8'd8, "R1 div8 rate", count - c0, 8);
        wr(3'd0, ctrl(2'b10, 2'b00, 2'b00));
        idle(3); c0 = count; idle(128);
        chk(count - c0 == 8'd2, "R1 div64 rate", count - c0, 2);
        wr(3'd0, ctrl(2'b00, 2'b00, 2'b00));
        idle(2); c0 = count; idle(40);
        chk(count == c0, "R1 stopped holds", count, c0);
    endtask

    // R2, R3: external edges and select-rewrite edges
    task automatic t_ext_switch();
        wr(3'd1, 8'h40);
        @(negedge clk) ext_clk = 1'b1;
        idle(2);
        wr(3'd0, ctrl(2'b11, 2'b00, 2'b00));
        idle(2);
        chk(count == 8'h40, "R3 low-to-high rewrite no count", count, 8'h40);
        @(negedge clk) ext_clk = 1'b0;
        idle(2);
        chk(count == 8'h41, "R2 ext fall counts", count, 8'h41);
        @(negedge clk) ext_clk = 1'b1;
        idle(2);
        chk(count == 8'h41, "R2 ext rise no count", count, 8'h41);
        wr(3'd0, ctrl(2'b00, 2'b00, 2'b00));
        idle(2);
        chk(count == 8'h42, "R3 high-to-low rewrite counts once", count, 8'h42);
        idle(10);
        chk(count == 8'h42, "R3 single spurious count", count, 8'h42);
    endtask

    // R4: write wins over a same-cycle count edge
    task automatic t_write_prio();
        wr(3'd0, ctrl(2'b11, 2'b00, 2'b00));
        @(negedge clk);
        ext_clk = 1'b0; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        idle(2);
        chk(count == 8'h55, "R4 write beats count", count, 8'h55);
        @(negedge clk) ext_clk = 1'b1;
        idle(2);
    endtask

    // R5: wrap and overflow flag
    task automatic t_wrap();
        wr(3'd1, 8'hFF);
        chk(ovf_flag == 1'b0, "R5 no flag before wrap", ovf_flag, 0);
        @(negedge clk) ext_clk = 1'b0;
        idle(2);
        chk(count == 8'h00, "R5 wrap to zero", count, 0);
        chk(ovf_flag == 1'b1, "R5 overflow set", ovf_flag, 1);
        wr(3'd4, 8'h04);
        idle(1);
        chk(ovf_flag == 1'b0, "R5 overflow cleared", ovf_flag, 0);
        @(negedge clk) ext_clk = 1'b1;
        wr(3'd0, ctrl(2'b00, 2'b00, 2'b00));
        idle(2);
    endtask

    // R7, R8: every action pair on a double match from both pin levels
    task automatic t_combos();
        wr(3'd3, 8'h00);
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    logic [1:0] w;
                    logic exp_pin;
                    wr(3'd0, ctrl(2'b00, (s != 0) ? 2'b10 : 2'b01, 2'b00));
                    wr(3'd2, 8'h20);
                    wr(3'd1, 8'h20);
                    idle(2);
                    chk(tmr_out == s[0], "R7 single A action sets level", tmr_out, s);
                    wr(3'd4, 8'h03);
                    wr(3'd0, ctrl(2'b00, a[1:0], b[1:0]));
                    wr(3'd2, 8'h30);
                    wr(3'd3, 8'h30);
                    wr(3'd1, 8'h30);
                    idle(2);
                    w = (a > b) ? a[1:0] : b[1:0];
                    case (w)
                        2'b00: exp_pin = s[0];
                        2'b01: exp_pin = 1'b0;
                        2'b10: exp_pin = 1'b1;
                        default: exp_pin = ~s[0];
                    endcase
                    chk(tmr_out == exp_pin, "R8 priority on double match", tmr_out, exp_pin);
                    chk(match_a_flag && match_b_flag, "R6 both flags on double match",
                        {match_a_flag, match_b_flag}, 3);
                end
            end
        end
    endtask

    // R6: flag clear by writing 1, per bit
    task automatic t_flag_clear();
        wr(3'd4, 8'h01);
        idle(1);
        chk(!match_a_flag && match_b_flag, "R6 clear A only",
            {match_a_flag, match_b_flag}, 1);
        wr(3'd4, 8'h02);
        idle(1);
        chk(!match_b_flag, "R6 clear B", match_b_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_rates();
        t_ext_switch();
        t_write_prio();
        t_wrap();
        t_combos();
        t_flag_clear();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule